// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sets the instruction timing for a small core with separate program and data memories. It divides the oscillator clock into four one-hot phase strobes. One pass through all four phases is one instruction cycle.

While one instruction executes, the next word is read from program memory, so one instruction completes per cycle. The program counter drives the program-memory address and holds it for the whole cycle. At the end of the fourth phase the returned word enters the instruction register, and the execute-valid flag goes high for the next cycle.

When the execute logic reports that the running instruction changed the program counter, the sequencer loads the new target. It also marks the word that was just prefetched as invalid, so the following cycle runs as a NOP. Decode, the ALU and the register file sit outside this block.

Top module: `quad_phase_seq`

## Requirements
- R1: While reset is held and at the first sampling after it is released: `phase_q` = 4'b0001, `imem_addr` = 0 (the reset vector), `exec_valid` = 0 and `instr_reg` = 0.
- R2: Exactly one bit of `phase_q` is high in every clock period. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The strobe moves Q1, Q2, Q3, Q4 and then back to Q1, one step per clock.
- R3: `imem_addr` holds the same value through all four phases of a cycle. It changes only on the clock edge that ends Q4.
- R4: Without a taken redirect, `imem_addr` advances by one per instruction cycle and wraps from 2^ADDR_W-1 to 0.
- R5: On the edge that ends Q4, `instr_reg` takes the `imem_rdata` value present during Q4 and `exec_valid` is set, unless a redirect is taken. Both then stay constant for the next four phases.
- R6: The first instruction cycle after reset only fetches: `exec_valid` stays 0 in all four of its phases.
- R7: A redirect is taken when `pc_chg` is high in Q4 while `exec_valid` = 1. `imem_addr` then becomes `pc_target`, the next cycle has `exec_valid` = 0 (NOP), and the cycle after that executes the word at `pc_target`.
- R8: `pc_chg` in phases Q1, Q2 or Q3 has no effect on `imem_addr`, `instr_reg` or `exec_valid`.
- R9: `pc_chg` during a cycle with `exec_valid` = 0 is ignored: the address advances by one and the fetched word becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rdata | input | INSTR_W | Program-memory read word for `imem_addr` |
| pc_chg | input | 1 | The executing instruction altered the program counter |
| pc_target | input | ADDR_W | New program-counter value when `pc_chg` is high |
| phase_q | output | 4 | One-hot phase strobes Q1..Q4 (bit 0 = Q1) |
| imem_addr | output | ADDR_W | Program-memory address (program counter) |
| instr_reg | output | INSTR_W | Instruction register |
| exec_valid | output | 1 | `instr_reg` holds a real instruction in this cycle |

## Verification
Two things meet on the edge that ends Q4: the capture of the prefetched word, and a redirect raised by the instruction now executing. The bench raises `pc_chg` in Q4 of a valid cycle and checks that the capture is cancelled, with `exec_valid` low for one full cycle and the address equal to the target. It then checks that the target word executes one cycle later. The bench also raises `pc_chg` in the early phases and during the NOP cycle itself. In those cases the fetch must go ahead exactly as in a plain sequential sweep. That sweep runs through the whole reduced address space, including the wrap.

// File: rtl/qseq_pkg.sv
`timescale 1ns/1ps
package qseq_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_Q1 = 0;
  localparam int PH_Q2 = 1;
  localparam int PH_Q3 = 2;
  localparam int PH_Q4 = 3;
  typedef logic [NUM_PHASES-1:0] phase_t;
  localparam phase_t PHASE_RESET = phase_t'(1);
endpackage

// File: rtl/qseq_phase_ring.sv
`timescale 1ns/1ps
module qseq_phase_ring
  import qseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase_o
);
  phase_t ring_q;

  always_ff @(posedge clk) begin
    if (rst) ring_q <= PHASE_RESET;
    else     ring_q <= {ring_q[NUM_PHASES-2:0], ring_q[NUM_PHASES-1]};
  end

  assign phase_o = ring_q;

  // R2: one strobe per period, fixed rotation
  p_one_hot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q) == 1);

  generate
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_step
      p_rotate_r2: assert property (@(posedge clk) disable iff (rst)
        ring_q[g] && !rst |=> rst || ring_q[(g + 1) % NUM_PHASES]);
    end
  endgenerate
endmodule

// File: rtl/qseq_prog_counter.sv
`timescale 1ns/1ps
module qseq_prog_counter #(
  parameter int          ADDR_W    = 13,
  parameter int unsigned RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_end_i,
  input  logic              take_redir_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(RESET_VEC);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)                pc_q <= VEC;
    else if (cycle_end_i) begin
      if (take_redir_i)     pc_q <= target_i;
      else                  pc_q <= pc_q + ONE;
    end
  end

  assign pc_o = pc_q;

  // R3: address frozen inside an instruction cycle
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cycle_end_i |=> rst || $stable(pc_q));
  // R4: sequential advance with wrap
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    cycle_end_i && !take_redir_i |=> rst || pc_q == $past(pc_q) + ONE);
endmodule

// File: rtl/qseq_instr_latch.sv
`timescale 1ns/1ps
module qseq_instr_latch #(
  parameter int INSTR_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cycle_end_i,
  input  logic               squash_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic               valid_o
);
  logic [INSTR_W-1:0] ir_q;
  logic               valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= '0;
      valid_q <= 1'b0;
    end else if (cycle_end_i) begin
      ir_q    <= word_i;
      valid_q <= !squash_i;
    end
  end

  assign ir_o    = ir_q;
  assign valid_o = valid_q;

  // R5: register and flag change only at the end of Q4
  p_ir_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cycle_end_i |=> rst || ($stable(ir_q) && $stable(valid_q)));
  // R5: unsquashed capture yields a valid instruction
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    cycle_end_i && !squash_i |=> rst || (valid_q && ir_q == $past(word_i)));
endmodule

// File: rtl/quad_phase_seq.sv
`timescale 1ns/1ps
module quad_phase_seq
  import qseq_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          INSTR_W   = 14,
  parameter int unsigned RESET_VEC = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               pc_chg,
  input  logic [ADDR_W-1:0]  pc_target,
  output logic [3:0]         phase_q,
  output logic [ADDR_W-1:0]  imem_addr,
  output logic [INSTR_W-1:0] instr_reg,
  output logic               exec_valid
);
  phase_t            phase_w;
  logic              cycle_end;
  logic              take_redir;
  logic [ADDR_W-1:0] pc_w;
  logic [INSTR_W-1:0] ir_w;
  logic              valid_w;

  qseq_phase_ring u_ring (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase_w)
  );

  assign cycle_end  = phase_w[PH_Q4];
  assign take_redir = cycle_end && pc_chg && valid_w;

  qseq_prog_counter #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
  ) u_pc (
    .clk          (clk),
    .rst          (rst),
    .cycle_end_i  (cycle_end),
    .take_redir_i (take_redir),
    .target_i     (pc_target),
    .pc_o         (pc_w)
  );

  qseq_instr_latch #(
    .INSTR_W (INSTR_W)
  ) u_ir (
    .clk         (clk),
    .rst         (rst),
    .cycle_end_i (cycle_end),
    .squash_i    (take_redir),
    .word_i      (imem_rdata),
    .ir_o        (ir_w),
    .valid_o     (valid_w)
  );

  assign phase_q    = phase_w;
  assign imem_addr  = pc_w;
  assign instr_reg  = ir_w;
  assign exec_valid = valid_w;

  // R7: taken redirect loads target and yields a NOP cycle
  p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    phase_q[3] && pc_chg && exec_valid |=>
      rst || (!exec_valid && imem_addr == $past(pc_target)));
  // R8: pc_chg outside Q4 leaves the address alone
  p_early_chg_r8: assert property (@(posedge clk) disable iff (rst)
    pc_chg && !phase_q[3] |=> rst || $stable(imem_addr));
  // R9: pc_chg during a NOP cycle does not redirect
  p_nop_chg_r9: assert property (@(posedge clk) disable iff (rst)
    phase_q[3] && pc_chg && !exec_valid |=>
      rst || (exec_valid && imem_addr == $past(imem_addr) + ADDR_W'(1)));
  // R6: reset leaves the first cycle fetch-only
  p_first_fetch_r6: assert property (@(posedge clk)
    rst |=> !exec_valid);
endmodule

// File: tb/quad_phase_seq_tb_top.sv
`timescale 1ns/1ps
module quad_phase_seq_tb_top;
  localparam int AW = 5;
  localparam int IW = 14;
  localparam int AMASK = (1 << AW) - 1;
  localparam int IMASK = (1 << IW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] imem_rdata;
  logic          pc_chg = 1'b0;
  logic [AW-1:0] pc_target = '0;
  logic [3:0]    phase_q;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] instr_reg;
  logic          exec_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int    exp_pc = 0;
  bit    exp_v = 0;
  int    exp_ir = 0;
  string pc_tag = "R4";
  string v_tag = "R6";

  always #10 clk = ~clk;

  function automatic int word_at(input int a);
    return ((a * 613) + 91 + (a << 9)) & IMASK;
  endfunction

  assign imem_rdata = IW'(word_at(int'(imem_addr)));

  quad_phase_seq #(.ADDR_W(AW), .INSTR_W(IW), .RESET_VEC(0)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_rdata (imem_rdata),
    .pc_chg     (pc_chg),
    .pc_target  (pc_target),
    .phase_q    (phase_q),
    .imem_addr  (imem_addr),
    .instr_reg  (instr_reg),
    .exec_valid (exec_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one instruction cycle; mask bit p raises pc_chg in phase p
  task automatic run_cycle(input int mask, input int target);
    for (int p = 0; p < 4; p++) begin
      chk(phase_q == 4'(1 << p), "R2", int'(phase_q), 1 << p);
      chk(int'(imem_addr) == exp_pc, (p == 0) ? pc_tag : "R3", int'(imem_addr), exp_pc);
      chk(exec_valid == exp_v, v_tag, int'(exec_valid), int'(exp_v));
      if (exp_v) chk(int'(instr_reg) == exp_ir, "R5", int'(instr_reg), exp_ir);
      pc_chg    = mask[p];
      pc_target = AW'(target);
      @(posedge clk);
      @(negedge clk);
    end
    pc_chg = 1'b0;
    if (mask[3] && exp_v) begin
      exp_pc = target & AMASK;
      exp_v  = 0;
      pc_tag = "R7";
      v_tag  = "R7";
    end else begin
      exp_ir = word_at(exp_pc);
      exp_v  = 1;
      exp_pc = (exp_pc + 1) & AMASK;
      pc_tag = mask[3] ? "R9" : ((mask != 0) ? "R8" : "R4");
      v_tag  = mask[3] ? "R9" : "R5";
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(phase_q == 4'b0001, "R1", int'(phase_q), 1);
    chk(imem_addr == '0, "R1", int'(imem_addr), 0);
    chk(exec_valid == 1'b0, "R1", int'(exec_valid), 0);
    chk(instr_reg == '0, "R1", int'(instr_reg), 0);
    // fetch-only first cycle (R6), then sweep past the address wrap (R4)
    for (int c = 0; c < 40; c++) run_cycle(0, 0);
    run_cycle(4'b1000, 7);   // R7 taken redirect
    run_cycle(4'b1000, 20);  // R9 ignored during NOP
    run_cycle(4'b0111, 25);  // R8 early phases ignored
    run_cycle(4'b1000, 31);  // R7 redirect to top address
    run_cycle(4'b1111, 3);   // R9 NOP cycle, all phases raised
    run_cycle(4'b1111, 3);   // R7 only Q4 counts
    for (int c = 0; c < 6; c++) run_cycle(0, 0);
    // synchronous reset in mid-cycle
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(phase_q == 4'b0001 && imem_addr == '0 && !exec_valid, "R1",
        int'({phase_q, exec_valid}), 2);
    rst = 1'b0;
    exp_pc = 0; exp_v = 0; pc_tag = "R1"; v_tag = "R6";
    run_cycle(4'b1000, 9);   // R6 fetch-only, redirect cannot be taken
    run_cycle(0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule